// File: doc/BRIEF.md
# Clock Root Command and Configuration Register Bank

This block is the software-facing register bank of a single clock root. Software programs a source select, a pre-divider, a mode field, a hardware clock-control enable and three counter words (M, N and D) through a simple single-cycle register port. Every write lands in a shadow copy. The configuration that drives the downstream source multiplexer and divider changes only after software requests a commit through the command register.

A commit request crosses into the root clock domain through a two-flop synchronizer. After a fixed number of root-clock cycles it copies the shadow values onto the active outputs, and an acknowledgement travels back the same way. Until that acknowledgement arrives the update bit reads 1, so software can poll it. Four dirty flags show which shadow words were written since the last commit. A force-enable bit keeps the root running. A read-only status bit reports whether the root is currently off.

Top module: `clkroot_regbank`

## Requirements
- R1: After reset the command word (byte address 0x0) reads 0x8000_0000: root off, no commit pending, no dirty flag. All active configuration outputs are 0 and `root_en` is 0.
- R2: Writes to the config word (0x4), M (0x8), N (0xC) or D (0x10) do not change any active output until a commit completes.
- R3: Command bits 4, 5, 6 and 7 read 1 after a write to config, N, M and D respectively.
- R4: Writing 1 to command bit 0 starts a commit. Bit 0 reads 1 while the commit is pending and clears itself when the commit is done. At that point the active outputs equal the shadow values and bits 7:4 read 0.
- R5: The config word keeps the pre-divider in bits 4:0, the source select in bits 10:8, the mode in bits 13:12 and the hardware clock-control enable in bit 20; all other bits read 0. M, N and D keep and read back their low 16 bits.
- R6: Command bit 1 is a read/write force-enable. While it is 1, `root_en` is 1 and bit 31 reads 0. With force-enable 0 and no `root_req`, bit 31 reads 1.
- R7: A high `root_req` input also turns the root on: `root_en` is 1 and bit 31 reads 0.
- R8: While a commit is pending, writes to config, M, N and D are ignored. They change neither the shadow values nor the dirty flags.
- R9: Unmapped or misaligned addresses read 0, and writes to them change no register.
- R10: While a commit is pending, writing 0 to bit 0 does not cancel it, and writing 1 again does not start a second one.
- R11: A commit requested with no dirty flag set still completes, and bit 0 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| addr | input | 5 | Byte address |
| we | input | 1 | Write enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after the address |
| root_clk | input | 1 | Root output clock that times the commit |
| root_req | input | 1 | Clock request from downstream consumers (register port domain) |
| root_en | output | 1 | Root enable to the downstream gate |
| div_o | output | 5 | Active pre-divider |
| src_o | output | 3 | Active source select |
| mode_o | output | 2 | Active counter mode |
| hwctl_o | output | 1 | Active hardware clock-control enable |
| m_o | output | 16 | Active M word |
| n_o | output | 16 | Active N word |
| d_o | output | 16 | Active D word |

## Verification
The first commit uses all-ones in the config word and distinct patterns in M, N and D. This separates each field position and shows that no word is crossed into another's output. A second commit changes only the config word, which shows that untouched words keep their earlier active values. A commit with no dirty flag confirms that completion does not depend on pending changes. Writes and update toggles issued inside the pending window tell a locked shadow apart from one that leaks late data into the active set.

// File: rtl/clkroot_regbank.sv
module clkroot_regbank #(
  parameter int AW   = 5,
  parameter int HIDW = 5,
  parameter int MNDW = 16,
  parameter int LAT  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic            root_clk,
  input  logic            root_req,
  output logic            root_en,
  output logic [HIDW-1:0] div_o,
  output logic [2:0]      src_o,
  output logic [1:0]      mode_o,
  output logic            hwctl_o,
  output logic [MNDW-1:0] m_o,
  output logic [MNDW-1:0] n_o,
  output logic [MNDW-1:0] d_o
);
  localparam int CW = $clog2(LAT + 1);

  logic sel_cmd, sel_cfg, sel_m, sel_n, sel_d;
  assign sel_cmd = (addr == AW'(5'h00));
  assign sel_cfg = (addr == AW'(5'h04));
  assign sel_m   = (addr == AW'(5'h08));
  assign sel_n   = (addr == AW'(5'h0C));
  assign sel_d   = (addr == AW'(5'h10));

  logic [HIDW-1:0] sh_div;
  logic [2:0]      sh_src;
  logic [1:0]      sh_mode;
  logic            sh_hw;
  logic [MNDW-1:0] sh_m, sh_n, sh_d;
  logic            force_q, upd_q, off_q, req_tgl;
  logic [3:0]      dirty;
  logic            ak_s1, ak_s2, ak_s3, done;
  logic            ack_tgl;

  assign done    = ak_s2 ^ ak_s3;
  assign root_en = force_q | root_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div <= '0; sh_src <= '0; sh_mode <= '0; sh_hw <= 1'b0;
      sh_m <= '0; sh_n <= '0; sh_d <= '0;
      force_q <= 1'b0; upd_q <= 1'b0; off_q <= 1'b1; req_tgl <= 1'b0;
      dirty <= '0;
      ak_s1 <= 1'b0; ak_s2 <= 1'b0; ak_s3 <= 1'b0;
    end else begin
      ak_s1 <= ack_tgl;
      ak_s2 <= ak_s1;
      ak_s3 <= ak_s2;
      off_q <= ~(force_q | root_req);
      if (done) begin
        upd_q <= 1'b0;
        dirty <= '0;
      end
      if (we && sel_cmd) begin
        force_q <= wdata[1];
        if (wdata[0] && !upd_q) begin
          upd_q   <= 1'b1;
          req_tgl <= ~req_tgl;
        end
      end
      if (we && !upd_q) begin
        if (sel_cfg) begin
          sh_div   <= wdata[HIDW-1:0];
          sh_src   <= wdata[10:8];
          sh_mode  <= wdata[13:12];
          sh_hw    <= wdata[20];
          dirty[0] <= 1'b1;
        end
        if (sel_n) begin sh_n <= wdata[MNDW-1:0]; dirty[1] <= 1'b1; end
        if (sel_m) begin sh_m <= wdata[MNDW-1:0]; dirty[2] <= 1'b1; end
        if (sel_d) begin sh_d <= wdata[MNDW-1:0]; dirty[3] <= 1'b1; end
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_cmd) begin
      rd_mux[0]   = upd_q;
      rd_mux[1]   = force_q;
      rd_mux[7:4] = dirty;
      rd_mux[31]  = off_q;
    end
    if (sel_cfg) begin
      rd_mux[HIDW-1:0] = sh_div;
      rd_mux[10:8]     = sh_src;
      rd_mux[13:12]    = sh_mode;
      rd_mux[20]       = sh_hw;
    end
    if (sel_m) rd_mux[MNDW-1:0] = sh_m;
    if (sel_n) rd_mux[MNDW-1:0] = sh_n;
    if (sel_d) rd_mux[MNDW-1:0] = sh_d;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;

  logic          rq_s1, rq_s2, rq_s3;
  logic [CW-1:0] cnt;

  always_ff @(posedge root_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_s1 <= 1'b0; rq_s2 <= 1'b0; rq_s3 <= 1'b0;
      cnt <= '0; ack_tgl <= 1'b0;
      div_o <= '0; src_o <= '0; mode_o <= '0; hwctl_o <= 1'b0;
      m_o <= '0; n_o <= '0; d_o <= '0;
    end else begin
      rq_s1 <= req_tgl;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
      if (rq_s2 ^ rq_s3) begin
        cnt <= CW'(LAT);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          div_o   <= sh_div;
          src_o   <= sh_src;
          mode_o  <= sh_mode;
          hwctl_o <= sh_hw;
          m_o     <= sh_m;
          n_o     <= sh_n;
          d_o     <= sh_d;
          ack_tgl <= ~ack_tgl;
        end
      end
    end
  end
endmodule

module clkroot_regbank_chk #(
  parameter int AW   = 5,
  parameter int HIDW = 5,
  parameter int MNDW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            we,
  input logic [AW-1:0]   addr,
  input logic            force_q,
  input logic            off_q,
  input logic            upd_q,
  input logic            done,
  input logic [3:0]      dirty,
  input logic [MNDW-1:0] sh_m,
  input logic [HIDW-1:0] div_o,
  input logic [MNDW-1:0] m_o,
  input logic [MNDW-1:0] n_o,
  input logic [MNDW-1:0] d_o
);
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_q && $past(!upd_q)) |-> ($stable(div_o) && $stable(m_o) && $stable(n_o) && $stable(d_o))); // R2
  AST_DIRTY_CFG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty[0]) |-> $past(we && addr == AW'(5'h04))); // R3
  AST_UPD_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_q) |-> $past(done)); // R4
  AST_FORCE_ROOT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |=> !off_q); // R6
  AST_PENDING_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && we && addr == AW'(5'h08)) |=> $stable(sh_m)); // R8
endmodule

bind clkroot_regbank clkroot_regbank_chk #(.AW(AW), .HIDW(HIDW), .MNDW(MNDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .force_q(force_q), .off_q(off_q),
  .upd_q(upd_q), .done(done), .dirty(dirty), .sh_m(sh_m), .div_o(div_o),
  .m_o(m_o), .n_o(n_o), .d_o(d_o)
);

// File: tb/sim_clkroot_regbank.sv
module sim_clkroot_regbank;
  logic        clk = 0, root_clk = 0, rst_n = 0;
  logic [4:0]  addr = '0;
  logic        we = 0, root_req = 0;
  logic [31:0] wdata = '0, rdata;
  logic        root_en, hwctl_o;
  logic [4:0]  div_o;
  logic [2:0]  src_o;
  logic [1:0]  mode_o;
  logic [15:0] m_o, n_o, d_o;

  always #2.5 clk = ~clk;
  always #3.5 root_clk = ~root_clk;

  clkroot_regbank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .root_clk(root_clk), .root_req(root_req), .root_en(root_en),
    .div_o(div_o), .src_o(src_o), .mode_o(mode_o), .hwctl_o(hwctl_o),
    .m_o(m_o), .n_o(n_o), .d_o(d_o)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = 5'h1F;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); addr = a; we = 0;
    it.exp = e; it.tag = tag; q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 0;
    @(posedge clk); #1; v = rdata;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  task automatic wait_commit(input string tag);
    logic [31:0] v;
    int k;
    v = 32'h1;
    for (k = 0; k < 200 && v[0]; k++) peek(5'h00, v);
    chk({31'b0, v[0]}, 32'h0, tag);
  endtask

  always begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(rdata, it.exp, it.tag);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd_exp(5'h00, 32'h8000_0000, "R1");
    chk({div_o, src_o, mode_o, hwctl_o}, 0, "R1 cfg outputs");
    chk({m_o, n_o}, 0, "R1 m/n outputs");
    chk({d_o, 15'b0, root_en}, 0, "R1 d/root_en");

    wr(5'h04, 32'hFFFF_FFFF);
    rd_exp(5'h04, 32'h0010_371F, "R5 cfg mask");
    rd_exp(5'h00, 32'h8000_0010, "R3 cfg dirty");
    wr(5'h08, 32'hABCD_1234);
    rd_exp(5'h08, 32'h0000_1234, "R5 M width");
    rd_exp(5'h00, 32'h8000_0050, "R3 M dirty");
    wr(5'h0C, 32'h5555_00F0);
    wr(5'h10, 32'h1111_0F0F);
    rd_exp(5'h00, 32'h8000_00F0, "R3 N/D dirty");
    repeat (20) @(negedge clk);
    chk({div_o, src_o, mode_o, hwctl_o}, 0, "R2 cfg held");
    chk({m_o, n_o}, 0, "R2 m/n held");
    chk({16'b0, d_o}, 0, "R2 d held");

    wr(5'h00, 32'h1);
    rd_exp(5'h00, 32'h8000_00F1, "R4 pending");
    wr(5'h08, 32'h0000_7777);
    rd_exp(5'h08, 32'h0000_1234, "R8 shadow locked");
    rd_exp(5'h00, 32'h8000_00F1, "R8 dirty unchanged");
    wr(5'h00, 32'h0);
    rd_exp(5'h00, 32'h8000_00F1, "R10 no cancel");
    wait_commit("R4 self-clear");
    rd_exp(5'h00, 32'h8000_0000, "R4 dirty cleared");
    chk({27'b0, div_o}, 32'h1F, "R4 div");
    chk({26'b0, src_o, mode_o, hwctl_o}, {26'b0, 3'd7, 2'd3, 1'b1}, "R4 src/mode/hw");
    chk({m_o, n_o}, {16'h1234, 16'h00F0}, "R4 m/n (R8 late M dropped)");
    chk({16'b0, d_o}, 32'h0F0F, "R4 d");

    wr(5'h00, 32'h2);
    rd_exp(5'h00, 32'h0000_0002, "R6 force on");
    chk({31'b0, root_en}, 1, "R6 root_en");
    wr(5'h00, 32'h0);
    rd_exp(5'h00, 32'h8000_0000, "R6 force off");
    chk({31'b0, root_en}, 0, "R6 root_en off");

    @(negedge clk); root_req = 1;
    repeat (2) @(negedge clk);
    rd_exp(5'h00, 32'h0000_0000, "R7 request on");
    chk({31'b0, root_en}, 1, "R7 root_en");
    @(negedge clk); root_req = 0;
    repeat (2) @(negedge clk);

    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h06, 32'hFFFF_FFFF);
    rd_exp(5'h14, 32'h0, "R9 unmapped");
    rd_exp(5'h1C, 32'h0, "R9 unmapped high");
    rd_exp(5'h06, 32'h0, "R9 misaligned");
    rd_exp(5'h00, 32'h8000_0000, "R9 cmd untouched");
    rd_exp(5'h04, 32'h0010_371F, "R9 cfg untouched");

    wr(5'h00, 32'h1);
    rd_exp(5'h00, 32'h8000_0001, "R11 pending");
    wait_commit("R11 completes");
    chk({m_o, n_o}, {16'h1234, 16'h00F0}, "R11 outputs kept");

    wr(5'h04, 32'h0000_0203);
    wr(5'h00, 32'h1);
    wait_commit("R4 second commit");
    chk({26'b0, src_o, mode_o, hwctl_o}, {26'b0, 3'd2, 2'd0, 1'b0}, "R4 src second");
    chk({27'b0, div_o}, 32'h3, "R4 div second");
    chk({16'b0, m_o}, 32'h1234, "R2 M unchanged by cfg commit");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule